// File: doc/BRIEF.md
# 32-bit Integer ALU

A single-cycle arithmetic and logic unit for the execute stage of a load/store RISC integer core. Two 32-bit operands, a 5-bit shift amount and a 4-bit operation code select one of ten operations. The unit produces a 32-bit result and a flag that is high when that result is zero. Branch logic uses the zero flag to decide equal and not-equal branches.

One adder, run in subtract mode, serves subtraction and both set-less-than compares. A logarithmic shifter serves both shift directions by mirroring the bits at its input and its output. With the default parameter setting, the result, the zero flag and a valid strobe are registered, so they appear one clock after the operands are presented.

The unit has no multiply, divide, overflow trap or instruction decoding. A zero operand B turns the bitwise-NOR operation into a bitwise NOT. A 32-bit constant is built with the upper-constant placement operation followed by an OR with the lower half.

Top module: `int_alu`

## Requirements
- R1: Op code 0 (add) returns (A + B) modulo 2^32, wrapping with no exception. Adding 0xFFFFFFFF acts as subtracting one.
- R2: Op code 1 (subtract) returns (A - B) modulo 2^32.
- R3: Op code 2 returns bitwise A AND B. Op code 3 returns bitwise A OR B.
- R4: Op code 4 returns the bitwise inverse of (A OR B). With B equal to zero, the result is the bitwise NOT of A.
- R5: Op code 5 shifts A left by shamt (0 to 31) and fills the vacated low bits with zeros.
- R6: Op code 6 shifts A right by shamt (0 to 31) and fills the vacated high bits with zeros.
- R7: Op code 7 returns 1 when A < B as two's-complement numbers, and 0 otherwise. Bits 31:1 are always zero. 0xFFFFFFFF compared against 0x00000001 gives 1.
- R8: Op code 8 returns 1 when A < B as unsigned numbers, and 0 otherwise. Bits 31:1 are always zero. 0xFFFFFFFF compared against 0x00000001 gives 0.
- R9: Op code 9 returns B[15:0] in bits 31:16 with bits 15:0 cleared, and A has no effect. ORing this result with a zero-extended lower constant (op code 3) yields the full 32-bit constant.
- R10: zero_o is high exactly when the 32-bit result is zero.
- R11: result_o and zero_o take the value for the operands presented while in_valid_i is high, one rising clock edge later, and valid_o follows in_valid_i by one edge. While in_valid_i is low, result_o and zero_o hold their values.
- R12: While rst_ni is low, result_o, zero_o and valid_o are all zero.
- R13: Op codes 10 to 15 return a result of zero, so zero_o is high for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and op code are valid this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B; its low half is the constant for op code 9 |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Result |
| zero_o | output | 1 | High when the result is zero |
| valid_o | output | 1 | result_o and zero_o carry a new value |

## Verification
The hardest case to reach is the one where the signed and unsigned orderings disagree. This happens only when the sign bits of the two operands differ, and the compare then depends on the sign-bit rule rather than the borrow out of the adder. The stimulus applies the all-ones and one pair in both orders to both compares, adds an equal-operand pair, and includes a positive-against-negative case. Shifts are driven at amounts 0, 4 and 31 in both directions, which exercises every stage of the mirrored shifter. The hold behaviour is checked by changing all operands while in_valid_i is low.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2
  } logic_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic            carry;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign {carry, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};

  // compares are only meaningful in subtract mode: no carry means a borrow
  assign lt_u_o = ~carry;
  assign lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic_op_e       sel_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            right_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0]         fwd;
  logic [SHW:0][XLEN-1:0]  stage;

  // right shift = mirror, shift left, mirror back
  for (genvar g = 0; g < XLEN; g++) begin : g_mirror_in
    assign fwd[g] = right_i ? val_i[XLEN-1-g] : val_i[g];
  end

  assign stage[0] = fwd;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stage[s+1] = amt_i[s] ? (stage[s] << (2 ** s)) : stage[s];
  end

  for (genvar g = 0; g < XLEN; g++) begin : g_mirror_out
    assign res_o[g] = right_i ? stage[SHW][XLEN-1-g] : stage[SHW][g];
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SHW     = $clog2(XLEN),
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] result_o,
  output logic            zero_o,
  output logic            valid_o
);
  localparam int HALF = XLEN / 2;

  alu_op_e         op;
  logic            sub_mode;
  logic [XLEN-1:0] sum;
  logic            lt_s;
  logic            lt_u;
  logic_op_e       lg_sel;
  logic [XLEN-1:0] lg_res;
  logic [XLEN-1:0] sh_res;
  logic [XLEN-1:0] res_d;
  logic            zero_d;

  assign op       = alu_op_e'(op_i);
  assign sub_mode = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign lg_sel   = (op == OP_AND) ? LG_AND : (op == OP_OR) ? LG_OR : LG_NOR;

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_mode),
    .sum_o  (sum),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_logic #(.XLEN(XLEN)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lg_sel),
    .res_o (lg_res)
  );

  alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .val_i   (a_i),
    .amt_i   (shamt_i),
    .right_i (op == OP_SRL),
    .res_o   (sh_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:         res_d = sum;
      OP_AND, OP_OR, OP_NOR:  res_d = lg_res;
      OP_SLL, OP_SRL:         res_d = sh_res;
      OP_SLT:                 res_d = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                res_d = {{(XLEN-1){1'b0}}, lt_u};
      OP_LUI:                 res_d = {b_i[HALF-1:0], {HALF{1'b0}}};
      default:                res_d = '0;
    endcase
  end

  assign zero_d = ~|res_d;

  if (REG_OUT) begin : g_reg
    logic [XLEN-1:0] res_q;
    logic            zero_q;
    logic            valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q   <= '0;
        zero_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= in_valid_i;
        if (in_valid_i) begin
          res_q  <= res_d;
          zero_q <= zero_d;
        end
      end
    end

    assign result_o = res_q;
    assign zero_o   = zero_q;
    assign valid_o  = valid_q;
  end else begin : g_comb
    assign result_o = res_d;
    assign zero_o   = zero_d;
    assign valid_o  = in_valid_i;
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import alu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] b_i,
  input logic [XLEN-1:0] result_o,
  input logic            zero_o,
  input logic            valid_o
);
  localparam int HALF = XLEN / 2;

  if (REG_OUT) begin : g_chk
    logic armed;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
    end

    // R12
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        reset_clear_chk: assert (result_o == '0 && !zero_o && !valid_o);
      end
    end

    // R10
    zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      valid_o |-> (zero_o == (result_o == '0)));

    // R11
    valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      valid_o == $past(in_valid_i));

    // R11
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      !$past(in_valid_i) |-> ($stable(result_o) && $stable(zero_o)));

    // R7
    slt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      (valid_o && $past(op_i) == OP_SLT) |-> (result_o[XLEN-1:1] == '0));

    // R8
    sltu_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      (valid_o && $past(op_i) == OP_SLTU) |-> (result_o[XLEN-1:1] == '0));

    // R9
    upper_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      (valid_o && $past(op_i) == OP_LUI) |->
        (result_o == {$past(b_i[HALF-1:0]), {HALF{1'b0}}}));
  end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_int_alu_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .op_i       (op_i),
  .b_i        (b_i),
  .result_o   (result_o),
  .zero_o     (zero_o),
  .valid_o    (valid_o)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        zero_o;
  logic        valid_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int_alu dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .op_i       (op_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .shamt_i    (shamt_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .valid_o    (valid_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                        logic [4:0] sh, logic [31:0] exp);
    @(negedge clk_i);
    in_valid_i = 1'b1; op_i = op; a_i = a; b_i = b; shamt_i = sh;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(req, result_o, exp);
    check({req, "/R10 zero"}, {31'd0, zero_o}, {31'd0, exp == 32'd0});
    check({req, "/R11 valid"}, {31'd0, valid_o}, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R12 result", result_o, 32'd0);
    check("R12 zero", {31'd0, zero_o}, 32'd0);
    check("R12 valid", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 idle valid", {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_add();
    run_op("R1 add", 4'd0, 32'd5, 32'd7, 5'd0, 32'd12);
    run_op("R1 wrap", 4'd0, 32'hFFFF_FFFF, 32'd2, 5'd0, 32'd1);
    run_op("R1 minus one", 4'd0, 32'd100, 32'hFFFF_FFFF, 5'd0, 32'd99);
  endtask

  task automatic t_sub();
    run_op("R2 sub", 4'd1, 32'd10, 32'd3, 5'd0, 32'd7);
    run_op("R2 negative", 4'd1, 32'd3, 32'd10, 5'd0, 32'hFFFF_FFF9);
    run_op("R2 equal", 4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0, 32'd0);
  endtask

  task automatic t_logic();
    run_op("R3 and", 4'd2, 32'h0000_3C00, 32'h0000_0DC0, 5'd0, 32'h0000_0C00);
    run_op("R3 or", 4'd3, 32'h0000_3C00, 32'h0000_0DC0, 5'd0, 32'h0000_3DC0);
    run_op("R4 nor", 4'd4, 32'h0000_3C00, 32'h0000_0DC0, 5'd0, 32'hFFFF_C23F);
    run_op("R4 not", 4'd4, 32'h0000_3C00, 32'd0, 5'd0, 32'hFFFF_C3FF);
  endtask

  task automatic t_shift();
    run_op("R5 sll 31", 4'd5, 32'd1, 32'd0, 5'd31, 32'h8000_0000);
    run_op("R5 sll 4", 4'd5, 32'hF0F0_F0F0, 32'd0, 5'd4, 32'h0F0F_0F00);
    run_op("R5 sll 0", 4'd5, 32'hA5A5_0001, 32'd0, 5'd0, 32'hA5A5_0001);
    run_op("R6 srl 31", 4'd6, 32'h8000_0000, 32'd0, 5'd31, 32'd1);
    run_op("R6 srl 4", 4'd6, 32'hF0F0_F0F0, 32'd0, 5'd4, 32'h0F0F_0F0F);
    run_op("R6 srl 0", 4'd6, 32'hA5A5_0001, 32'd0, 5'd0, 32'hA5A5_0001);
  endtask

  task automatic t_compare();
    run_op("R7 neg<pos", 4'd7, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd1);
    run_op("R7 pos<neg", 4'd7, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'd0);
    run_op("R7 equal", 4'd7, 32'd9, 32'd9, 5'd0, 32'd0);
    run_op("R7 max vs min", 4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 32'd0);
    run_op("R8 big<one", 4'd8, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd0);
    run_op("R8 one<big", 4'd8, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'd1);
    run_op("R8 equal", 4'd8, 32'd9, 32'd9, 5'd0, 32'd0);
  endtask

  task automatic t_const();
    run_op("R9 upper", 4'd9, 32'hFFFF_FFFF, 32'h1234_AAAA, 5'd3, 32'hAAAA_0000);
    run_op("R9 build", 4'd3, 32'hAAAA_0000, 32'h0000_EAAB, 5'd0, 32'hAAAA_EAAB);
  endtask

  task automatic t_undef();
    for (int k = 10; k < 16; k++) begin
      run_op("R13 undefined", 4'(k), 32'hDEAD_BEEF, 32'h0BAD_F00D, 5'd7, 32'd0);
    end
  endtask

  task automatic t_hold();
    run_op("R11 load", 4'd0, 32'd40, 32'd2, 5'd0, 32'd42);
    @(negedge clk_i);
    op_i = 4'd1; a_i = 32'd0; b_i = 32'd0; in_valid_i = 1'b0;
    @(negedge clk_i);
    check("R11 hold result", result_o, 32'd42);
    check("R11 hold zero", {31'd0, zero_o}, 32'd0);
    check("R11 hold valid", {31'd0, valid_o}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_compare();
    t_const();
    t_undef();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule